// File: doc/BRIEF.md
# Clock-Stepped One-Time Memory Programming Port

This block is the on-chip end of a programming path for a one-time program memory that holds 16-bit words. The external programmer has no address lines. It steers the block with a four-bit mode pattern and a slow step clock, and it moves data over an 8-bit bus. Every group of four step-clock pulses is one address cycle. The first two falling edges of a cycle move the low byte and then the high byte of the current word. The third falling edge moves the internal word pointer on by one. A programming-enable input stands in for the high-voltage condition. While it is low, nothing on the mode or clock pins has any effect.

The step clock, the mode pins and the enable are slow, asynchronous signals. The block passes them through a synchronizer and then works on falling edges it detects on the system clock. Writes leave the block as single-cycle strobes towards a behavioural memory array outside it. The word sent with a strobe is the old word combined by AND with the new byte in the selected lane, so a programmed 0 can never return to 1. In read/verify mode the block drives the selected byte of the current word onto the bus. In every other mode it releases the bus.

Top module: `otp_loader_port`

## Requirements
- R1: The mode pattern mode_sel = 4'b0101 (bit 0 is the first mode pin) is clear mode. It forces the word address and the in-cycle phase to zero.
- R2: The pattern 4'b1110 is write mode. In this mode the first falling step edge of a cycle writes bus_in into the low byte of the current word, and the second writes it into the high byte.
- R3: The word written is the stored word combined by AND with the new byte in its lane. Bits can only go from 1 to 0.
- R4: The pattern 4'b1100 is read/verify mode. In this mode bus_oe is 1. bus_out shows the high byte of the current word after exactly one falling edge of the cycle, and the low byte at every other phase.
- R5: In any enabled mode other than clear, the word address rises by one on the third falling step edge of every group of four. It holds at all other times.
- R6: The address runs from 0 to LAST_ADDR, and one step from LAST_ADDR returns it to 0.
- R7: The patterns 4'b1101 and 4'b1111, and every pattern not listed above, are program-inhibit. In inhibit the bus is released (bus_oe 0, bus_out 0) and no write strobe occurs, but the address still advances as in R5.
- R8: While prog_en is low, the mode pins and the step clock have no effect: no write occurs, the bus is released, the clear pattern leaves the address alone, and the in-cycle phase returns to zero. The address is kept.
- R9: After reset the address is 0, bus_oe and bus_out are 0, and mem_we is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prog_en | input | 1 | Programming enable (high-voltage condition present) |
| mode_sel | input | 4 | Mode pattern, bit 0 first pin |
| step_clk | input | 1 | Address-update clock from the programmer |
| bus_in | input | 8 | Byte driven by the programmer |
| bus_out | output | 8 | Byte driven by the block |
| bus_oe | output | 1 | Block drives the data bus |
| mem_addr | output | AW | Current word address towards the array |
| mem_rdata | input | 16 | Stored word at mem_addr, combinational read |
| mem_wdata | output | 16 | Word to store on a strobe |
| mem_we | output | 1 | Single-cycle write strobe |

## Verification
The assertions assume two things about the array. First, mem_rdata returns the word at mem_addr in the same cycle. Second, mem_addr does not change while a strobe is pending. Without the first, the only-clear-bits property would be comparing against the wrong word.

The properties also assume slow external signals, which the synchronizer and edge detector depend on. Each mode pin, the enable and the step clock must stay steady for several system clocks. The mode must not change within a few cycles of a falling step edge. The stimulus keeps to this by changing one group of pins at a time on the falling system edge. After each change it waits six system clocks before the next change or before sampling, so every step-clock level is seen long after the mode has settled.

// File: rtl/otp_lp_pkg.sv
package otp_lp_pkg;

  typedef enum logic [1:0] {
    MODE_INH = 2'd0,
    MODE_CLR = 2'd1,
    MODE_WR  = 2'd2,
    MODE_RD  = 2'd3
  } lp_mode_e;

  // bit 0 of each pattern is the first mode pin
  localparam logic [3:0] PAT_CLR = 4'b0101;
  localparam logic [3:0] PAT_WR  = 4'b1110;
  localparam logic [3:0] PAT_RD  = 4'b1100;

  // Patterns outside the three active ones all fall back to inhibit
  function automatic lp_mode_e decode_mode(input logic [3:0] pins);
    lp_mode_e m;
    if (pins == PAT_CLR)      m = MODE_CLR;
    else if (pins == PAT_WR)  m = MODE_WR;
    else if (pins == PAT_RD)  m = MODE_RD;
    else                      m = MODE_INH;
    return m;
  endfunction

  // One-time cell behaviour: the new byte can only pull bits of its lane low
  function automatic logic [15:0] otp_merge(input logic [15:0] old_w,
                                            input logic [7:0]  new_b,
                                            input logic        hi_lane);
    logic [15:0] w;
    if (hi_lane) w = {old_w[15:8] & new_b, old_w[7:0]};
    else         w = {old_w[15:8], old_w[7:0] & new_b};
    return w;
  endfunction

  function automatic logic [7:0] byte_pick(input logic [15:0] w,
                                           input logic        hi_lane);
    return hi_lane ? w[15:8] : w[7:0];
  endfunction

endpackage

// File: rtl/otp_lp_sync.sv
module otp_lp_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/otp_lp_seq.sv
module otp_lp_seq
  import otp_lp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_s,
  input  logic [3:0] pins_s,
  input  logic       step_s,
  output lp_mode_e   mode,
  output logic [1:0] phase,
  output logic       step_fall,
  output logic       addr_step,
  output logic       addr_clr
);

  logic step_prev;

  assign mode      = en_s ? decode_mode(pins_s) : MODE_INH;
  assign step_fall = en_s & step_prev & ~step_s;
  assign addr_clr  = (mode == MODE_CLR);
  // third falling edge of a cycle: phase is 2 before that edge
  assign addr_step = step_fall & (phase == 2'd2) & ~addr_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_prev <= 1'b0;
      phase     <= 2'd0;
    end else begin
      step_prev <= step_s;
      if (!en_s || addr_clr) phase <= 2'd0;
      else if (step_fall)    phase <= phase + 2'd1;
    end
  end

endmodule

// File: rtl/otp_lp_addr.sv
module otp_lp_addr #(
  parameter int LAST_ADDR = 'h0FFF,
  parameter int AW        = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  output logic [AW-1:0] addr
);

  localparam logic [AW-1:0] LAST = AW'(LAST_ADDR);

  function automatic logic [AW-1:0] next_addr(input logic [AW-1:0] a);
    return (a == LAST) ? '0 : a + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     addr <= '0;
    else if (clr)   addr <= '0;
    else if (step)  addr <= next_addr(addr);
  end

endmodule

// File: rtl/otp_lp_data.sv
module otp_lp_data
  import otp_lp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  lp_mode_e    mode,
  input  logic [1:0]  phase,
  input  logic        step_fall,
  input  logic [7:0]  bus_in,
  input  logic [15:0] mem_rdata,
  output logic        wr_lo,
  output logic        wr_hi,
  output logic        mem_we,
  output logic [15:0] mem_wdata,
  output logic [7:0]  bus_out,
  output logic        bus_oe
);

  logic in_write;
  logic in_read;

  assign in_write  = (mode == MODE_WR);
  assign in_read   = (mode == MODE_RD);
  assign wr_lo     = in_write & step_fall & (phase == 2'd0);
  assign wr_hi     = in_write & step_fall & (phase == 2'd1);
  assign mem_we    = wr_lo | wr_hi;
  assign mem_wdata = otp_merge(mem_rdata, bus_in, wr_hi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_oe  <= 1'b0;
      bus_out <= 8'h00;
    end else begin
      bus_oe  <= in_read;
      bus_out <= in_read ? byte_pick(mem_rdata, phase == 2'd1) : 8'h00;
    end
  end

endmodule

// File: rtl/otp_loader_port.sv
module otp_loader_port
  import otp_lp_pkg::*;
#(
  parameter int LAST_ADDR   = 'h0FFF,
  parameter int SYNC_STAGES = 2,
  localparam int AW         = $clog2(LAST_ADDR + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prog_en,
  input  logic [3:0]    mode_sel,
  input  logic          step_clk,
  input  logic [7:0]    bus_in,
  output logic [7:0]    bus_out,
  output logic          bus_oe,
  output logic [AW-1:0] mem_addr,
  input  logic [15:0]   mem_rdata,
  output logic [15:0]   mem_wdata,
  output logic          mem_we
);

  localparam int SW = 6;

  logic [SW-1:0] raw_pins;
  logic [SW-1:0] sync_pins;
  logic          en_s;
  logic [3:0]    pins_s;
  logic          step_s;
  lp_mode_e      mode;
  logic [1:0]    phase;
  logic          step_fall;
  logic          addr_step;
  logic          addr_clr;
  logic          wr_lo;
  logic          wr_hi;

  assign raw_pins = {prog_en, mode_sel, step_clk};
  assign en_s     = sync_pins[5];
  assign pins_s   = sync_pins[4:1];
  assign step_s   = sync_pins[0];

  otp_lp_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_pins),
    .q     (sync_pins)
  );

  otp_lp_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_s      (en_s),
    .pins_s    (pins_s),
    .step_s    (step_s),
    .mode      (mode),
    .phase     (phase),
    .step_fall (step_fall),
    .addr_step (addr_step),
    .addr_clr  (addr_clr)
  );

  otp_lp_addr #(.LAST_ADDR(LAST_ADDR), .AW(AW)) u_addr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (addr_clr),
    .step  (addr_step),
    .addr  (mem_addr)
  );

  otp_lp_data u_data (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .phase     (phase),
    .step_fall (step_fall),
    .bus_in    (bus_in),
    .mem_rdata (mem_rdata),
    .wr_lo     (wr_lo),
    .wr_hi     (wr_hi),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .bus_out   (bus_out),
    .bus_oe    (bus_oe)
  );

endmodule

// File: rtl/otp_loader_port_chk.sv
module otp_loader_port_chk
  import otp_lp_pkg::*;
#(
  parameter int LAST_ADDR = 'h0FFF,
  parameter int AW        = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en_s,
  input lp_mode_e      mode,
  input logic [1:0]    phase,
  input logic          step_fall,
  input logic          addr_step,
  input logic          mem_we,
  input logic          bus_oe,
  input logic [7:0]    bus_out,
  input logic [AW-1:0] mem_addr,
  input logic [15:0]   mem_wdata,
  input logic [15:0]   mem_rdata
);

  localparam logic [AW-1:0] LAST = AW'(LAST_ADDR);

  AST_CLR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_CLR) |=> (mem_addr == '0 && phase == 2'd0)); // R1

  AST_WE_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mode == MODE_WR && phase[1] == 1'b0)); // R2

  AST_ONLY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ((mem_wdata & ~mem_rdata) == 16'h0000)); // R3

  AST_OE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> ($past(mode) == MODE_RD)); // R4

  AST_ADDR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    addr_step |=> (mem_addr == (($past(mem_addr) == LAST) ? '0 : $past(mem_addr) + 1'b1))); // R5

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_step && mode != MODE_CLR) |=> $stable(mem_addr)); // R5

  AST_ADDR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    mem_addr <= LAST); // R6

  AST_BUS_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe |-> (bus_out == 8'h00)); // R7

  AST_OFF_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    !en_s |-> (!mem_we && !step_fall)); // R8

  AST_OFF_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    !en_s |=> (phase == 2'd0)); // R8

endmodule

bind otp_loader_port otp_loader_port_chk #(.LAST_ADDR(LAST_ADDR), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en_s      (en_s),
  .mode      (mode),
  .phase     (phase),
  .step_fall (step_fall),
  .addr_step (addr_step),
  .mem_we    (mem_we),
  .bus_oe    (bus_oe),
  .bus_out   (bus_out),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_rdata (mem_rdata)
);

// File: tb/test_otp_loader_port.sv
module test_otp_loader_port;

  localparam int LAST = 63;
  localparam int AW   = $clog2(LAST + 1);
  localparam logic [3:0] P_CLR = 4'b0101;
  localparam logic [3:0] P_WR  = 4'b1110;
  localparam logic [3:0] P_RD  = 4'b1100;
  localparam logic [3:0] P_INH = 4'b1101;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          prog_en = 1'b0;
  logic [3:0]    mode_sel = P_INH;
  logic          step_clk = 1'b0;
  logic [7:0]    bus_in = 8'h00;
  logic [7:0]    bus_out;
  logic          bus_oe;
  logic [AW-1:0] mem_addr;
  logic [15:0]   mem_rdata;
  logic [15:0]   mem_wdata;
  logic          mem_we;

  logic [15:0] mem [LAST+1];
  int n_chk  = 0;
  int n_fail = 0;
  int we_cnt = 0;

  always #4 clk = ~clk;

  otp_loader_port #(.LAST_ADDR(LAST)) i_otp_loader_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .prog_en   (prog_en),
    .mode_sel  (mode_sel),
    .step_clk  (step_clk),
    .bus_in    (bus_in),
    .bus_out   (bus_out),
    .bus_oe    (bus_oe),
    .mem_addr  (mem_addr),
    .mem_rdata (mem_rdata),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we)
  );

  assign mem_rdata = mem[mem_addr];

  always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;
  always @(negedge clk) if (rst_n && mem_we) we_cnt <= we_cnt + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic set_pins(input logic [3:0] p);
    @(negedge clk);
    mode_sel = p;
    settle();
  endtask

  task automatic pulse(input logic [7:0] b);
    @(negedge clk);
    bus_in = b;
    step_clk = 1'b1;
    settle();
    step_clk = 1'b0;
    settle();
  endtask

  task automatic cycle4(input logic [7:0] lo, input logic [7:0] hi);
    pulse(lo); pulse(hi); pulse(8'h00); pulse(8'h00);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic t_reset();
    chk("R9 addr", 32'(mem_addr), 0);
    chk("R9 oe", 32'(bus_oe), 0);
    chk("R9 out", 32'(bus_out), 0);
    chk("R9 we", 32'(we_cnt), 0);
  endtask

  task automatic t_write();
    @(negedge clk); prog_en = 1'b1;
    set_pins(P_CLR);
    chk("R1 addr zero", 32'(mem_addr), 0);
    set_pins(P_WR);
    cycle4(8'h3C, 8'hA5);
    chk("R2 word0", 32'(mem[0]), 32'hA53C);
    chk("R5 addr after cycle", 32'(mem_addr), 1);
    cycle4(8'h12, 8'h34);
    chk("R2 word1", 32'(mem[1]), 32'h3412);
    chk("R2 strobes", 32'(we_cnt), 4);
    set_pins(P_CLR);
    chk("R1 clear from 2", 32'(mem_addr), 0);
  endtask

  task automatic t_and();
    set_pins(P_WR);
    cycle4(8'hC3, 8'hFF);
    chk("R3 and merge", 32'(mem[0]), 32'hA500);
    set_pins(P_CLR);
  endtask

  task automatic t_read();
    set_pins(P_RD);
    chk("R4 oe", 32'(bus_oe), 1);
    chk("R4 lo ph0", 32'(bus_out), 32'h00);
    pulse(8'h00); chk("R4 hi ph1", 32'(bus_out), 32'hA5);
    pulse(8'h00); chk("R4 lo ph2", 32'(bus_out), 32'h00);
    pulse(8'h00); chk("R5 third edge", 32'(mem_addr), 1);
    chk("R4 lo next word", 32'(bus_out), 32'h12);
    pulse(8'h00); chk("R4 lo ph0 w1", 32'(bus_out), 32'h12);
    pulse(8'h00); chk("R4 hi w1", 32'(bus_out), 32'h34);
    set_pins(P_CLR);
  endtask

  task automatic t_inhibit();
    int w0;
    w0 = we_cnt;
    set_pins(P_INH);
    chk("R7 oe off", 32'(bus_oe), 0);
    chk("R7 out zero", 32'(bus_out), 0);
    cycle4(8'h00, 8'h00);
    chk("R7 addr advances", 32'(mem_addr), 1);
    set_pins(4'b1111);
    cycle4(8'h00, 8'h00);
    set_pins(4'b0000);
    cycle4(8'h00, 8'h00);
    chk("R7 addr after 3", 32'(mem_addr), 3);
    chk("R7 no strobes", 32'(we_cnt), 32'(w0));
    chk("R7 word0 kept", 32'(mem[0]), 32'hA500);
    set_pins(P_CLR);
  endtask

  task automatic t_disable();
    int w0;
    set_pins(P_INH);
    cycle4(8'h00, 8'h00);
    set_pins(P_RD);
    pulse(8'h00);
    chk("R4 hi before off", 32'(bus_out), 32'h34);
    @(negedge clk); prog_en = 1'b0;
    settle();
    chk("R8 oe off", 32'(bus_oe), 0);
    w0 = we_cnt;
    set_pins(P_WR);
    cycle4(8'h00, 8'h00);
    chk("R8 no strobe", 32'(we_cnt), 32'(w0));
    chk("R8 word kept", 32'(mem[1]), 32'h3412);
    chk("R8 addr kept", 32'(mem_addr), 1);
    set_pins(P_CLR);
    chk("R8 clear ignored", 32'(mem_addr), 1);
    set_pins(P_RD);
    @(negedge clk); prog_en = 1'b1;
    settle();
    chk("R8 phase cleared", 32'(bus_out), 32'h12);
    set_pins(P_CLR);
  endtask

  task automatic t_wrap();
    set_pins(P_INH);
    for (int i = 0; i < LAST; i++) cycle4(8'h00, 8'h00);
    chk("R6 at last", 32'(mem_addr), LAST);
    cycle4(8'h00, 8'h00);
    chk("R6 wrapped", 32'(mem_addr), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i <= LAST; i++) mem[i] = 16'hFFFF;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    settle();
    t_reset();
    t_write();
    t_and();
    t_read();
    t_inhibit();
    t_disable();
    t_wrap();
    finish_run();
  end

endmodule